// File: doc/BRIEF.md
# Per-Thread Runahead Mode Controller

This block tracks, for every hardware thread of a simultaneously multithreaded core, whether that thread is running normally or running ahead speculatively. A thread stops waiting on a long-latency load: when one of its loads misses the second-level cache, the thread switches into a speculative mode. In that mode it keeps fetching and executing, and the loads it issues act as prefetches. The block records the program counter of the load that caused the switch.

When the data for that triggering miss comes back, the block raises a one-cycle flush request for that thread only. In the same cycle it presents the recorded program counter as the point where normal fetch restarts. The thread is back in normal mode on the following cycle. Threads are handled independently, so one thread being speculative never holds the others back.

For each thread, a saturating counter records how many instructions were retired speculatively during the most recent runahead episode. All counters are presented side by side on one output bus.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset, every thread is in normal mode: `runahead_mode`, `flush_req`, `restart_valid` and every `spec_count` field are all zero.
- R2: A miss event (`miss_valid`) for a thread in normal mode sets that thread's `runahead_mode` bit on the next cycle and records `miss_pc` as its checkpoint.
- R3: Miss events for a thread that is already in runahead mode leave its checkpoint unchanged.
- R4: A return event (`ret_valid`) for a thread in runahead mode causes the following on the next cycle:
  - that thread's `flush_req` bit is high for exactly one cycle, and its `runahead_mode` bit is cleared;
  - `restart_valid` is high, `restart_tid` holds the thread number in binary, and `restart_pc` holds the checkpoint.
- R5: The cycle after a flush, the thread is in normal mode with no flush and no restart. A miss event that arrives during the flush cycle is ignored, and a later miss starts a new episode.
- R6: A return event for a thread in normal mode is ignored: no flush, no restart and no change of mode.
- R7: When a miss and a return arrive in the same cycle, they interact as follows:
  - same thread, in runahead: the return wins and the checkpoint is kept;
  - same thread, in normal mode: the miss wins and the return is ignored;
  - different threads: both events take effect.
- R8: The speculative retire counter of thread t works as follows:
  - It sits at bits [t*16 +: 16] of `spec_count`.
  - It clears when the thread enters runahead.
  - It adds one for each cycle in which `spec_retire[t]` is high while the thread is in runahead, and ignores `spec_retire[t]` otherwise.
  - It holds its value after the episode ends.
  - It saturates at 65535.
- R9: Entering, leaving or flushing one thread never changes the mode or flush bits of another thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | A load missed the second-level cache this cycle |
| miss_tid | input | TID_W | Thread of the missing load (binary) |
| miss_pc | input | PC_W | Program counter of the missing load |
| ret_valid | input | 1 | Data of a triggering miss returned this cycle |
| ret_tid | input | TID_W | Thread whose miss returned |
| spec_retire | input | NUM_THREADS | Per-thread retire strobe, one instruction per cycle |
| runahead_mode | output | NUM_THREADS | Per-thread runahead flag |
| flush_req | output | NUM_THREADS | Per-thread one-cycle flush request |
| restart_valid | output | 1 | A restart program counter is presented |
| restart_tid | output | TID_W | Thread being restarted |
| restart_pc | output | PC_W | Program counter where normal fetch resumes |
| spec_count | output | NUM_THREADS*CNT_W | Per-thread speculative retire counts |

## Verification
The critical overlap is a miss event and a return event landing in the same cycle. The bench drives both on one clock edge in three configurations:
- same thread while it is in runahead, where the flush must win and the restart address must still be the old checkpoint;
- same thread while it is normal, where the miss must win with no flush;
- two different threads, where one thread must flush in the very cycle the other enters runahead.

A miss delivered during a thread's own flush cycle is also checked. It must leave the thread normal, and the next episode's restart address is compared against the newer miss so that a stray capture would show.

// File: rtl/runahead_pkg.sv
package runahead_pkg;

    typedef enum logic [1:0] {
        TS_NORMAL = 2'd0,
        TS_SPEC   = 2'd1,
        TS_FLUSH  = 2'd2
    } thr_state_e;

endpackage

// File: rtl/runahead_sat_counter.sv
module runahead_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] val;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.val = '0;
        end else if (inc && (s_q.val != CNT_MAX)) begin
            s_d.val = s_q.val + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.val;
endmodule

// File: rtl/runahead_thread_fsm.sv
module runahead_thread_fsm
    import runahead_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_hit,
    input  logic [PC_W-1:0]  miss_pc,
    input  logic             ret_hit,
    input  logic             retire_pulse,
    output logic             spec_mode,
    output logic             flush_now,
    output logic [PC_W-1:0]  ckpt_pc,
    output logic [CNT_W-1:0] spec_cnt
);
    typedef struct packed {
        thr_state_e      st;
        logic [PC_W-1:0] pc;
    } fsm_state_t;

    fsm_state_t s_d, s_q;
    logic       entering_d;

    always_comb begin
        s_d        = s_q;
        entering_d = 1'b0;
        unique case (s_q.st)
            TS_NORMAL: begin
                if (miss_hit) begin
                    s_d.st     = TS_SPEC;
                    s_d.pc     = miss_pc;
                    entering_d = 1'b1;
                end
            end
            TS_SPEC: begin
                if (ret_hit) begin
                    s_d.st = TS_FLUSH;
                end
            end
            TS_FLUSH: begin
                s_d.st = TS_NORMAL;
            end
            default: begin
                s_d.st = TS_NORMAL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= TS_NORMAL;
            s_q.pc <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign spec_mode = (s_q.st == TS_SPEC);
    assign flush_now = (s_q.st == TS_FLUSH);
    assign ckpt_pc   = s_q.pc;

    runahead_sat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (entering_d),
        .inc   (spec_mode & retire_pulse),
        .count (spec_cnt)
    );
endmodule

// File: rtl/runahead_restart_sel.sv
module runahead_restart_sel #(
    parameter int NUM_THREADS = 4,
    parameter int PC_W        = 32,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic [NUM_THREADS-1:0]      flush_vec,
    input  logic [NUM_THREADS*PC_W-1:0] ckpt_flat,
    output logic                        sel_valid,
    output logic [TID_W-1:0]            sel_tid,
    output logic [PC_W-1:0]             sel_pc
);
    always_comb begin
        sel_valid = |flush_vec;
        sel_tid   = '0;
        sel_pc    = '0;
        for (int i = 0; i < NUM_THREADS; i++) begin
            if (flush_vec[i]) begin
                sel_tid = sel_tid | TID_W'(i);
                sel_pc  = sel_pc | ckpt_flat[i*PC_W +: PC_W];
            end
        end
    end
endmodule

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
    parameter int NUM_THREADS = 4,
    parameter int PC_W        = 32,
    parameter int CNT_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         miss_valid,
    input  logic [TID_W-1:0]             miss_tid,
    input  logic [PC_W-1:0]              miss_pc,
    input  logic                         ret_valid,
    input  logic [TID_W-1:0]             ret_tid,
    input  logic [NUM_THREADS-1:0]       spec_retire,
    output logic [NUM_THREADS-1:0]       runahead_mode,
    output logic [NUM_THREADS-1:0]       flush_req,
    output logic                         restart_valid,
    output logic [TID_W-1:0]             restart_tid,
    output logic [PC_W-1:0]              restart_pc,
    output logic [NUM_THREADS*CNT_W-1:0] spec_count
);
    logic [NUM_THREADS*PC_W-1:0] ckpt_flat;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        logic miss_hit, ret_hit;
        assign miss_hit = miss_valid && (miss_tid == TID_W'(t));
        assign ret_hit  = ret_valid  && (ret_tid  == TID_W'(t));

        runahead_thread_fsm #(
            .PC_W  (PC_W),
            .CNT_W (CNT_W)
        ) u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .miss_hit     (miss_hit),
            .miss_pc      (miss_pc),
            .ret_hit      (ret_hit),
            .retire_pulse (spec_retire[t]),
            .spec_mode    (runahead_mode[t]),
            .flush_now    (flush_req[t]),
            .ckpt_pc      (ckpt_flat[t*PC_W +: PC_W]),
            .spec_cnt     (spec_count[t*CNT_W +: CNT_W])
        );
    end

    runahead_restart_sel #(
        .NUM_THREADS (NUM_THREADS),
        .PC_W        (PC_W)
    ) u_sel (
        .flush_vec (flush_req),
        .ckpt_flat (ckpt_flat),
        .sel_valid (restart_valid),
        .sel_tid   (restart_tid),
        .sel_pc    (restart_pc)
    );
endmodule

// File: rtl/runahead_ctrl_chk.sv
module runahead_ctrl_chk #(
    parameter int NUM_THREADS = 4,
    parameter int PC_W        = 32,
    parameter int CNT_W       = 16,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         miss_valid,
    input logic [TID_W-1:0]             miss_tid,
    input logic                         ret_valid,
    input logic [TID_W-1:0]             ret_tid,
    input logic [NUM_THREADS-1:0]       runahead_mode,
    input logic [NUM_THREADS-1:0]       flush_req,
    input logic                         restart_valid,
    input logic [TID_W-1:0]             restart_tid,
    input logic [NUM_THREADS*CNT_W-1:0] spec_count
);
    // R4: a single return per cycle means at most one flush at a time
    p_single_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_req));

    // R4: restart presented exactly when a flush is requested
    p_restart_with_flush_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|flush_req) |-> restart_valid);

    p_restart_tid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |-> flush_req[restart_tid]);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
        // R4: a flush is always preceded by a runahead cycle
        p_flush_after_spec_r4: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req[t] |-> $past(runahead_mode[t]));

        // R5: flush lasts one cycle and leaves the thread normal
        p_flush_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
            flush_req[t] |=> (!flush_req[t] && !runahead_mode[t]));

        // R2: miss on a normal, non-flushing thread enters runahead
        p_enter_on_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (miss_valid && miss_tid == TID_W'(t) && !runahead_mode[t] && !flush_req[t])
            |=> runahead_mode[t]);

        // R6: return for a normal thread produces no flush
        p_ret_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ret_valid && ret_tid == TID_W'(t) && !runahead_mode[t]) |=> !flush_req[t]);

        // R8: counter never falls during an episode
        p_cnt_monotonic_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (runahead_mode[t] && $past(runahead_mode[t]))
            |-> (spec_count[t*CNT_W +: CNT_W] >= $past(spec_count[t*CNT_W +: CNT_W])));
    end
endmodule

bind runahead_ctrl runahead_ctrl_chk #(
    .NUM_THREADS (NUM_THREADS),
    .PC_W        (PC_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .miss_valid    (miss_valid),
    .miss_tid      (miss_tid),
    .ret_valid     (ret_valid),
    .ret_tid       (ret_tid),
    .runahead_mode (runahead_mode),
    .flush_req     (flush_req),
    .restart_valid (restart_valid),
    .restart_tid   (restart_tid),
    .spec_count    (spec_count)
);

// File: tb/runahead_ctrl_bench.sv
module runahead_ctrl_bench;
    localparam int NT    = 4;
    localparam int PW    = 32;
    localparam int CW    = 16;
    localparam int TW    = 2;
    localparam int LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          miss_valid;
    logic [TW-1:0] miss_tid;
    logic [PW-1:0] miss_pc;
    logic          ret_valid;
    logic [TW-1:0] ret_tid;
    logic [NT-1:0] spec_retire;
    logic [NT-1:0] runahead_mode;
    logic [NT-1:0] flush_req;
    logic          restart_valid;
    logic [TW-1:0] restart_tid;
    logic [PW-1:0] restart_pc;
    logic [NT*CW-1:0] spec_count;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;

    runahead_ctrl #(.NUM_THREADS(NT), .PC_W(PW), .CNT_W(CW)) u_runahead_ctrl (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_tid(miss_tid), .miss_pc(miss_pc),
        .ret_valid(ret_valid), .ret_tid(ret_tid), .spec_retire(spec_retire),
        .runahead_mode(runahead_mode), .flush_req(flush_req),
        .restart_valid(restart_valid), .restart_tid(restart_tid),
        .restart_pc(restart_pc), .spec_count(spec_count)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        miss_valid = 1'b0; ret_valid = 1'b0; spec_retire = '0;
    endtask

    function automatic logic [CW-1:0] cnt_of(input int t);
        return spec_count[t*CW +: CW];
    endfunction

    task automatic do_miss(input int t, input logic [PW-1:0] pc);
        miss_valid = 1'b1; miss_tid = TW'(t); miss_pc = pc;
    endtask

    task automatic do_ret(input int t);
        ret_valid = 1'b1; ret_tid = TW'(t);
    endtask

    task automatic check_flush(input int t, input logic [PW-1:0] pc, input string req);
        chk(flush_req == NT'(1 << t), req, "flush vector", 64'(flush_req), 64'(1 << t));
        chk(restart_valid && restart_tid == TW'(t), req, "restart tid",
            64'(restart_tid), 64'(t));
        chk(restart_pc == pc, req, "restart pc", 64'(restart_pc), 64'(pc));
        chk(!runahead_mode[t], req, "mode cleared on flush", 64'(runahead_mode), 0);
    endtask

    task automatic t_reset();
        chk(runahead_mode == '0 && flush_req == '0 && !restart_valid, "R1", "reset flags",
            {runahead_mode, flush_req, 7'(restart_valid)}, 0);
        chk(spec_count == '0, "R1", "reset counts", spec_count, 0);
    endtask

    task automatic t_enter_exit();
        do_miss(1, 32'h0000_1000); step(); idle();
        chk(runahead_mode == 4'b0010, "R2", "enter thread1", 64'(runahead_mode), 64'b0010);
        chk(flush_req == '0, "R9", "no flush elsewhere", 64'(flush_req), 0);
        do_miss(1, 32'h0000_2000); step(); idle();
        chk(runahead_mode == 4'b0010, "R3", "stays in runahead", 64'(runahead_mode), 64'b0010);
        spec_retire = 4'b0010; step(); step(); step(); idle();
        do_ret(1); step(); idle();
        check_flush(1, 32'h0000_1000, "R4");
        chk(cnt_of(1) == 16'd3, "R8", "episode count", 64'(cnt_of(1)), 3);
        step();
        chk(flush_req == '0 && !restart_valid && runahead_mode == '0, "R5",
            "normal after flush", {flush_req, 7'(restart_valid)}, 0);
        chk(cnt_of(1) == 16'd3, "R8", "count held after exit", 64'(cnt_of(1)), 3);
    endtask

    task automatic t_ignore_ret();
        do_ret(3); step(); idle();
        chk(flush_req == '0 && !restart_valid && runahead_mode == '0, "R6",
            "return to normal thread", {flush_req, 7'(restart_valid)}, 0);
        step();
        chk(flush_req == '0 && runahead_mode == '0, "R6", "still idle",
            64'(flush_req), 0);
    endtask

    task automatic t_flush_miss();
        do_miss(0, 32'h0000_A000); step(); idle();
        do_ret(0); step(); idle();
        check_flush(0, 32'h0000_A000, "R4");
        do_miss(0, 32'h0000_B000); step(); idle();
        chk(runahead_mode[0] == 1'b0, "R5", "miss during flush ignored",
            64'(runahead_mode), 0);
        do_miss(0, 32'h0000_C000); step(); idle();
        chk(runahead_mode[0] == 1'b1, "R5", "re-entry", 64'(runahead_mode), 1);
        do_ret(0); step(); idle();
        check_flush(0, 32'h0000_C000, "R5");
        step();
    endtask

    task automatic t_same_cycle();
        do_miss(2, 32'h0000_2200); do_ret(2); step(); idle();
        chk(runahead_mode == 4'b0100 && flush_req == '0, "R7", "miss wins on normal",
            {runahead_mode, flush_req}, 8'h40);
        do_miss(2, 32'h0000_2300); do_ret(2); step(); idle();
        check_flush(2, 32'h0000_2200, "R7");
        step();
        do_miss(0, 32'h0000_0400); step(); idle();
        do_miss(3, 32'h0000_3300); do_ret(0); step(); idle();
        check_flush(0, 32'h0000_0400, "R7");
        chk(runahead_mode == 4'b1000, "R9", "other thread entered same cycle",
            64'(runahead_mode), 64'b1000);
        step();
        chk(runahead_mode == 4'b1000 && flush_req == '0, "R9", "thread3 unaffected",
            {runahead_mode, flush_req}, 8'h80);
        do_ret(3); step(); idle();
        check_flush(3, 32'h0000_3300, "R4");
        step();
    endtask

    task automatic t_counter();
        spec_retire = 4'b0010; step(); step(); idle();
        chk(cnt_of(1) == 16'd3, "R8", "retire outside runahead ignored", 64'(cnt_of(1)), 3);
        do_miss(1, 32'h0000_5000); step(); idle();
        chk(cnt_of(1) == 16'd0, "R8", "clear on entry", 64'(cnt_of(1)), 0);
        spec_retire = 4'b0010;
        for (int i = 0; i < 65540; i++) step();
        idle();
        chk(cnt_of(1) == 16'hFFFF, "R8", "saturation", 64'(cnt_of(1)), 64'hFFFF);
        step();
        chk(cnt_of(1) == 16'hFFFF, "R8", "held at max", 64'(cnt_of(1)), 64'hFFFF);
        do_ret(1); step(); idle();
        check_flush(1, 32'h0000_5000, "R4");
        step();
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; miss_tid = '0; miss_pc = '0; ret_tid = '0; idle();
        step(); step(); step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_enter_exit();
        t_ignore_ret();
        t_flush_miss();
        t_same_cycle();
        t_counter();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule